// File: doc/BRIEF.md
# Transmit Channel Interrupt Status Controller

This block turns the level status flags of one audio transmit FIFO into interrupt state for software. It watches four inputs from the FIFO side: a half-empty level, an empty level, a transmitter-busy level, and a one-cycle underrun event. It keeps a sticky underrun flag. It holds a raw interrupt status register and a software enable register, and it drives one registered interrupt line.

The raw status register is not refreshed on every clock. It is recomputed only when the surrounding logic signals a refresh point (any bus access or a codec data request) or when a register write arrives. Each raw bit mirrors the level of its source at that moment; nothing in the raw register is edge-latched. Software clears the sticky underrun flag by writing the clear register with the underrun-clear bit set. A read port returns the raw status, the masked status or the enable register, zero-extended to the bus width.

Top module: `txirq_ctrl`

## Requirements
- R1: After reset the raw status, the enable register, the underrun flag and `irq_o` are all zero.
- R2: A pulse on `underrun_evt_i` sets the underrun flag. The flag stays set until a write to the clear register (`wr_sel_i`=1) with data bit 2 set. If the event and such a write fall in the same cycle, the flag stays set.
- R3: At each refresh, raw status bit 2 takes the value of the underrun flag as updated in that cycle.
- R4: At each refresh, raw status bit 0 takes the level of `fifo_half_i`.
- R5: At each refresh, raw status bit 1 is 1 only when `fifo_empty_i` is 1 and `tx_busy_i` is 0.
- R6: A refresh happens on a cycle with `refresh_i` or `wr_en_i` high. In any other cycle the raw status holds its value, whatever the flags do.
- R7: A write with `wr_sel_i`=0 loads the enable register from data bits 2..0. Bits 6..3 of the enable register always read as zero.
- R8: `irq_o` is registered. It is 1 exactly when raw status AND enable is nonzero, and it changes on the same clock edge as the register update that causes the change.
- R9: Readback: `rd_sel_i`=0 returns raw status, 1 returns raw AND enable, 2 returns the enable register, 3 returns zero. Only the low 7 bits can be nonzero, and raw bits 6..3 are always zero.
- R10: A clear-register write with data bit 2 at 0 leaves the underrun flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_half_i | input | 1 | FIFO at or below half full |
| fifo_empty_i | input | 1 | FIFO empty |
| tx_busy_i | input | 1 | Transmitter still shifting data |
| underrun_evt_i | input | 1 | One-cycle underrun event |
| refresh_i | input | 1 | Refresh point (bus access or codec data request) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable register, 1 clear register |
| wr_data_i | input | 7 | Write data |
| rd_sel_i | input | 2 | Readback select |
| rd_data_o | output | DATA_W | Readback data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench moves the FIFO flags in cycles with no refresh. A design that tracked the flags continuously would show the new level early. It also drives a busy-but-empty FIFO, where a design that ignored busy would raise the completion bit. It covers an underrun event and a clear write in the same cycle, which a design that gave the clear priority would lose. It issues clear writes without the underrun-clear bit, which a design decoding the wrong bit would act on. Masked readback and `irq_o` are checked with partial enables, which catches an OR taken before masking or an interrupt line that lags the status by a cycle.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
    localparam int STAT_W     = 7;
    localparam int BIT_TXREQ  = 0;
    localparam int BIT_DONE   = 1;
    localparam int BIT_UR     = 2;
    localparam int UR_CLR_BIT = 2;
    localparam logic [STAT_W-1:0] USED_MASK =
        STAT_W'((1 << BIT_TXREQ) | (1 << BIT_DONE) | (1 << BIT_UR));

    typedef enum logic {
        WSEL_ENABLE = 1'b0,
        WSEL_CLEAR  = 1'b1
    } wsel_e;

    typedef enum logic [1:0] {
        RSEL_RAW    = 2'd0,
        RSEL_MASKED = 2'd1,
        RSEL_ENABLE = 2'd2,
        RSEL_NONE   = 2'd3
    } rsel_e;

    typedef struct packed {
        logic              ur;
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] en;
        logic              irq;
    } txirq_state_t;
endpackage

// File: rtl/txirq_src.sv
module txirq_src
    import txirq_pkg::*;
(
    input  logic              fifo_half_i,
    input  logic              fifo_empty_i,
    input  logic              tx_busy_i,
    input  logic              ur_q_i,
    input  logic              ur_evt_i,
    input  logic              clr_hit_i,
    output logic              ur_d_o,
    output logic [STAT_W-1:0] raw_o
);
    // sticky underrun flag: a new event outranks a clear in the same cycle
    always_comb begin
        ur_d_o = ur_q_i;
        if (clr_hit_i) ur_d_o = 1'b0;
        if (ur_evt_i)  ur_d_o = 1'b1;
    end

    always_comb begin
        raw_o            = '0;
        raw_o[BIT_TXREQ] = fifo_half_i;
        raw_o[BIT_DONE]  = fifo_empty_i & ~tx_busy_i;
        raw_o[BIT_UR]    = ur_d_o;
    end
endmodule

// File: rtl/txirq_rd.sv
module txirq_rd
    import txirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel_i,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [STAT_W-1:0] en_i,
    output logic [DATA_W-1:0] data_o
);
    logic [STAT_W-1:0] pick;

    always_comb begin
        unique case (rsel_e'(sel_i))
            RSEL_RAW:    pick = stat_i;
            RSEL_MASKED: pick = stat_i & en_i;
            RSEL_ENABLE: pick = en_i;
            default:     pick = '0;
        endcase
    end

    generate
        if (DATA_W > STAT_W) begin : g_ext
            assign data_o = {{(DATA_W-STAT_W){1'b0}}, pick};
        end else begin : g_flat
            assign data_o = pick;
        end
    endgenerate
endmodule

// File: rtl/txirq_ctrl.sv
module txirq_ctrl
    import txirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_half_i,
    input  logic              fifo_empty_i,
    input  logic              tx_busy_i,
    input  logic              underrun_evt_i,
    input  logic              refresh_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    txirq_state_t      d, q;
    logic              clr_hit;
    logic              ur_nxt;
    logic [STAT_W-1:0] raw_nxt;

    assign clr_hit = wr_en_i && (wr_sel_i == WSEL_CLEAR) && wr_data_i[UR_CLR_BIT];

    txirq_src u_src (
        .fifo_half_i  (fifo_half_i),
        .fifo_empty_i (fifo_empty_i),
        .tx_busy_i    (tx_busy_i),
        .ur_q_i       (q.ur),
        .ur_evt_i     (underrun_evt_i),
        .clr_hit_i    (clr_hit),
        .ur_d_o       (ur_nxt),
        .raw_o        (raw_nxt)
    );

    always_comb begin
        d    = q;
        d.ur = ur_nxt;
        if (wr_en_i && (wr_sel_i == WSEL_ENABLE)) begin
            d.en = wr_data_i & USED_MASK;
        end
        if (refresh_i || wr_en_i) begin
            d.stat = raw_nxt;
        end
        d.irq = |(d.stat & d.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    txirq_rd #(.DATA_W(DATA_W)) u_rd (
        .sel_i  (rd_sel_i),
        .stat_i (q.stat),
        .en_i   (q.en),
        .data_o (rd_data_o)
    );

    assign irq_o = q.irq;
endmodule

// File: rtl/txirq_ctrl_chk.sv
module txirq_ctrl_chk
    import txirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_half_i,
    input logic              fifo_empty_i,
    input logic              tx_busy_i,
    input logic              underrun_evt_i,
    input logic              refresh_i,
    input logic              wr_en_i,
    input logic              wr_sel_i,
    input logic              clr_bit_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o,
    input logic              ur_q,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] en_q
);
    AST_UR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_evt_i |=> ur_q); // R2

    AST_UR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_q && !(wr_en_i && wr_sel_i && clr_bit_i)) |=> ur_q); // R10

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(refresh_i || wr_en_i) |=> $stable(stat_q)); // R6

    AST_HALF_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i || wr_en_i) |=> (stat_q[BIT_TXREQ] == $past(fifo_half_i))); // R4

    AST_DONE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i || wr_en_i) |=> (stat_q[BIT_DONE] == $past(fifo_empty_i && !tx_busy_i))); // R5

    AST_UR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i || wr_en_i) |=> (stat_q[BIT_UR] == ur_q)); // R3

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(stat_q & en_q))); // R8

    AST_EN_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~USED_MASK) == '0); // R7

    AST_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:STAT_W] == '0); // R9
endmodule

bind txirq_ctrl txirq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fifo_half_i    (fifo_half_i),
    .fifo_empty_i   (fifo_empty_i),
    .tx_busy_i      (tx_busy_i),
    .underrun_evt_i (underrun_evt_i),
    .refresh_i      (refresh_i),
    .wr_en_i        (wr_en_i),
    .wr_sel_i       (wr_sel_i),
    .clr_bit_i      (wr_data_i[2]),
    .rd_data_o      (rd_data_o),
    .irq_o          (irq_o),
    .ur_q           (q.ur),
    .stat_q         (q.stat),
    .en_q           (q.en)
);

// File: tb/txirq_ctrl_test.sv
`timescale 1ns/1ps
module txirq_ctrl_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          half = 1'b0, empty = 1'b0, busy = 1'b0, evt = 1'b0;
    logic          refresh = 1'b0, wen = 1'b0, wsel = 1'b0;
    logic [6:0]    wdata = '0;
    logic [1:0]    rsel = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    bit m_ur = 0;
    int m_stat = 0;
    int m_en = 0;
    bit m_irq = 0;
    bit m_nur;

    always #4 clk = ~clk;

    txirq_ctrl #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .fifo_half_i(half), .fifo_empty_i(empty), .tx_busy_i(busy),
        .underrun_evt_i(evt), .refresh_i(refresh),
        .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdata),
        .rd_sel_i(rsel), .rd_data_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ur = 0; m_stat = 0; m_en = 0; m_irq = 0;
        end else begin
            if (evt)                                m_nur = 1;
            else if (wen && wsel && wdata[2])       m_nur = 0;
            else                                    m_nur = m_ur;
            if (wen && !wsel) m_en = int'(wdata) % 8;
            if (refresh || wen) begin
                m_stat = 0;
                if (half)           m_stat = m_stat + 1;
                if (empty && !busy) m_stat = m_stat + 2;
                if (m_nur)          m_stat = m_stat + 4;
            end
            m_ur  = m_nur;
            m_irq = (m_stat & m_en) != 0;
        end
    end

    function automatic int exp_rd(input int sel);
        case (sel)
            0: return m_stat;
            1: return m_stat & m_en;
            2: return m_en;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk("R8 irq vs model", irq, m_irq);
        chk("R9 readback vs model", rdata, exp_rd(int'(rsel)));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic quiet();
        evt = 0; refresh = 0; wen = 0; wsel = 0; wdata = '0;
    endtask

    task automatic look(input int sel, input string tag, input int exp);
        rsel = 2'(sel);
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        look(0, "R1 raw after reset", 0);
        look(2, "R1 enable after reset", 0);
        chk("R1 irq after reset", irq, 0);
        rst_n = 1;

        // flags move without any refresh point
        half = 1; busy = 1; tick();
        look(0, "R6 raw holds without refresh", 0);

        // enable write also refreshes
        wen = 1; wsel = 0; wdata = 7'h7F; tick(); quiet();
        look(2, "R7 enable keeps only bits 2..0", 7);
        look(0, "R4 half-empty mirrored", 1);
        chk("R8 irq raised by enabled bit", irq, 1);

        empty = 1; busy = 0; tick();
        look(0, "R6 raw holds while flags change", 1);
        refresh = 1; tick(); quiet();
        look(0, "R5 done when empty and idle", 3);

        busy = 1; refresh = 1; tick(); quiet();
        look(0, "R5 busy suppresses done", 1);

        evt = 1; tick(); quiet(); tick();
        look(0, "R6 underrun not shown before refresh", 1);
        refresh = 1; tick(); quiet();
        look(0, "R3 underrun mirrored at refresh", 5);

        wen = 1; wsel = 1; wdata = 7'h03; tick(); quiet();
        look(0, "R10 clear without bit 2 keeps underrun", 5);

        wen = 1; wsel = 0; wdata = 7'h02; tick(); quiet();
        look(1, "R9 masked readback all masked", 0);
        chk("R8 irq low when masked", irq, 0);

        wen = 1; wsel = 1; wdata = 7'h04; tick(); quiet();
        look(0, "R2 clear bit removes underrun", 1);

        evt = 1; wen = 1; wsel = 1; wdata = 7'h04; tick(); quiet();
        look(0, "R2 event beats clear", 5);

        busy = 0; refresh = 1; tick(); quiet();
        look(0, "R5 raw with all sources", 7);
        look(1, "R9 masked readback", 2);
        look(3, "R9 unused select reads zero", 0);
        chk("R8 irq from done bit", irq, 1);

        // randomized phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            half    = 1'($urandom);
            empty   = 1'($urandom);
            busy    = 1'($urandom);
            evt     = ($urandom % 8) == 0;
            refresh = ($urandom % 3) == 0;
            wen     = ($urandom % 6) == 0;
            wsel    = 1'($urandom);
            wdata   = 7'($urandom);
            rsel    = 2'($urandom);
            if (($urandom % 200) == 0) rst_n = 0; else rst_n = 1;
            tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule